// File: doc/BRIEF.md
# Pointer-plus-offset register load unit

This unit executes one two-byte prefixed load. It reads a 16-bit register pair from memory at an address formed by adding a 32-bit pointer register to the 16-bit HL offset. The opcode bytes arrive on a byte-wide strobe. The unit recognises the prefix byte 0x6D and decodes the following byte into a pointer choice and a destination choice. From the pointer's upper half it decides whether the address is logical, which means it is flagged for translation, or physical. It then reads the low byte and the high byte and writes the pair into the register file in a single write.

The controller is a single state machine, and every state except the first three lasts two clocks, counted by a `half` bit:

- `S_IDLE` goes to `S_PFX` on a valid 0x6D.
- `S_PFX` waits for the next valid byte. It goes to `S_DECODE` when the byte is legal and to `S_TRAP` when it is not.
- `S_TRAP` lasts one clock and returns to `S_IDLE`.
- The five two-clock steps run in order: `S_DECODE`, `S_ADDR`, `S_RD_LO`, `S_RD_HI`, `S_WBACK`. `S_WBACK` returns to `S_IDLE`.

The pointer register is selected through `ptr_sel`, and its value and HL are sampled in the second clock of `S_ADDR`.

Top module: `ptr_offset_load_unit`

## Requirements
- R1: In `S_IDLE` only a valid byte equal to 0x6D starts an instruction, and any other byte leaves `busy` low. Valid bytes that arrive while an instruction is in progress (after the second byte is accepted) are ignored.
- R2: Second byte fields: bits [7:6] select the destination on `rf_dst` (00 BC, 01 DE, 10 IX, 11 IY). Bits [5:4] select the pointer on `ptr_sel` (00 PW, 01 PX, 10 PY, 11 PZ).
- R3: The first read address is pointer plus zero-extended HL. For a physical address this is the low PHYS_W bits of the sum.
- R4: When pointer bits [31:16] are all ones, `mem_xlate` is high on both reads, and `mem_addr` carries the low 16 address bits with the upper bits zero.
- R5: Any other pointer gives `mem_xlate` low, and `mem_addr` carries the low PHYS_W bits of the address.
- R6: The byte read at the effective address forms `rf_wdata[7:0]`. The byte read at the effective address plus one, carried across all bits, forms `rf_wdata[15:8]`.
- R7: Clocks are counted from the edge that accepts the second byte. `mem_rd` is high in clocks 5 to 8, and `done` is high for exactly clock 10. `busy` is low in clock 11.
- R8: `rf_we` is asserted exactly once per instruction, after both reads, carrying the full 16-bit value.
- R9: If `alt_prefix` is high with the second byte and the destination is BC or DE, `rf_alt` is high on the write.
- R10: For IX or IY destinations, `rf_alt` is low on the write whatever `alt_prefix` was.
- R11: A second byte whose low nibble is not 0010 raises `illegal` for clock 1 only. No memory read follows, and the unit returns to idle in clock 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Opcode byte strobe |
| op_byte | input | 8 | Opcode byte |
| alt_prefix | input | 1 | Alternate-register prefix, sampled with the second byte |
| ptr_sel | output | 2 | Pointer register read select |
| ptr_val | input | 32 | Selected pointer register value |
| hl_val | input | 16 | HL offset register value |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | PHYS_W | Memory read address |
| mem_xlate | output | 1 | Address needs translation |
| mem_data | input | 8 | Read data, captured at the end of each read step |
| rf_we | output | 1 | Register file write enable |
| rf_dst | output | 2 | Destination pair code |
| rf_alt | output | 1 | Write goes to the alternate copy |
| rf_wdata | output | 16 | Value written |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-clock completion pulse |
| illegal | output | 1 | Illegal second byte |

## Verification
The checker watches four properties on every cycle:

- `done` is a single-clock pulse, and it is preceded by the read window and a one-clock gap.
- The translate flag never changes within a read pair.
- `rf_alt` stays low for IX and IY.
- An illegal byte is never followed by a read.

The scenarios are needed for the rest. These are the address arithmetic, including the carry into bit 16, wrap-around in the logical space and truncation above PHYS_W; the byte order in the written value; and the decoding of all sixteen field combinations. Prefix bytes that are ignored in idle and during an instruction are also shown only by the scenarios.

// File: rtl/pol_pkg.sv
package pol_pkg;
    localparam logic [7:0] PREFIX_BYTE = 8'h6D;
    localparam logic [3:0] OP2_NIBBLE  = 4'h2;

    typedef enum logic [3:0] {
        S_IDLE,
        S_PFX,
        S_TRAP,
        S_DECODE,
        S_ADDR,
        S_RD_LO,
        S_RD_HI,
        S_WBACK
    } pol_state_e;

    // destination pair codes; bit 1 set means an index register
    localparam logic [1:0] DST_BC = 2'b00;
    localparam logic [1:0] DST_DE = 2'b01;
    localparam logic [1:0] DST_IX = 2'b10;
    localparam logic [1:0] DST_IY = 2'b11;
endpackage

// File: rtl/pol_decode.sv
module pol_decode
    import pol_pkg::*;
(
    input  logic [7:0] op2,
    output logic       legal,
    output logic [1:0] dst,
    output logic [1:0] ptr
);
    assign legal = (op2[3:0] == OP2_NIBBLE);
    assign dst   = op2[7:6];
    assign ptr   = op2[5:4];
endmodule

// File: rtl/pol_addr.sv
module pol_addr #(
    parameter int PHYS_W = 24
) (
    input  logic [31:0]       ptr,
    input  logic [15:0]       hl,
    output logic [PHYS_W-1:0] ea,
    output logic              logical
);
    localparam int PAD_W = PHYS_W - 16;

    // bits above PHYS_W never reach the bus, so the sum is kept narrow
    assign ea      = ptr[PHYS_W-1:0] + {{PAD_W{1'b0}}, hl};
    assign logical = &ptr[31:16];
endmodule

// File: rtl/pol_bus_map.sv
module pol_bus_map #(
    parameter int PHYS_W = 24
) (
    input  logic [PHYS_W-1:0] ea_base,
    input  logic              hi_byte,
    input  logic              logical,
    output logic [PHYS_W-1:0] addr
);
    localparam int PAD_W = PHYS_W - 16;

    logic [PHYS_W-1:0] raw;

    assign raw = hi_byte ? (ea_base + {{(PHYS_W-1){1'b0}}, 1'b1}) : ea_base;

    generate
        if (PAD_W > 0) begin : g_pad
            assign addr = logical ? {{PAD_W{1'b0}}, raw[15:0]} : raw;
        end else begin : g_nopad
            assign addr = raw;
        end
    endgenerate
endmodule

// File: rtl/ptr_offset_load_unit.sv
module ptr_offset_load_unit
    import pol_pkg::*;
#(
    parameter int PHYS_W = 24   // 20 or 24 significant physical bits
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [7:0]        op_byte,
    input  logic              alt_prefix,
    output logic [1:0]        ptr_sel,
    input  logic [31:0]       ptr_val,
    input  logic [15:0]       hl_val,
    output logic              mem_rd,
    output logic [PHYS_W-1:0] mem_addr,
    output logic              mem_xlate,
    input  logic [7:0]        mem_data,
    output logic              rf_we,
    output logic [1:0]        rf_dst,
    output logic              rf_alt,
    output logic [15:0]       rf_wdata,
    output logic              busy,
    output logic              done,
    output logic              illegal
);
    pol_state_e state_q, state_d;
    logic       half_q, half_d;

    logic [1:0]        dst_q, ptr_q;
    logic              alt_q, log_q;
    logic [PHYS_W-1:0] ea_q;
    logic [7:0]        lo_q, hi_q;

    logic              dec_legal;
    logic [1:0]        dec_dst, dec_ptr;
    logic [PHYS_W-1:0] ea_sum;
    logic              ea_logical;

    pol_decode u_dec (
        .op2   (op_byte),
        .legal (dec_legal),
        .dst   (dec_dst),
        .ptr   (dec_ptr)
    );

    pol_addr #(.PHYS_W(PHYS_W)) u_addr (
        .ptr     (ptr_val),
        .hl      (hl_val),
        .ea      (ea_sum),
        .logical (ea_logical)
    );

    pol_bus_map #(.PHYS_W(PHYS_W)) u_map (
        .ea_base (ea_q),
        .hi_byte (state_q == S_RD_HI),
        .logical (log_q),
        .addr    (mem_addr)
    );

    // next state
    always_comb begin
        state_d = state_q;
        half_d  = 1'b0;
        unique case (state_q)
            S_IDLE:   if (op_valid && op_byte == PREFIX_BYTE) state_d = S_PFX;
            S_PFX:    if (op_valid) state_d = dec_legal ? S_DECODE : S_TRAP;
            S_TRAP:   state_d = S_IDLE;
            S_DECODE: if (!half_q) half_d = 1'b1; else state_d = S_ADDR;
            S_ADDR:   if (!half_q) half_d = 1'b1; else state_d = S_RD_LO;
            S_RD_LO:  if (!half_q) half_d = 1'b1; else state_d = S_RD_HI;
            S_RD_HI:  if (!half_q) half_d = 1'b1; else state_d = S_WBACK;
            S_WBACK:  if (!half_q) half_d = 1'b1; else state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            half_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            half_q  <= half_d;
        end
    end

    // datapath captures
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dst_q <= '0;
            ptr_q <= '0;
            alt_q <= 1'b0;
            log_q <= 1'b0;
            ea_q  <= '0;
            lo_q  <= '0;
            hi_q  <= '0;
        end else begin
            if (state_q == S_PFX && op_valid && dec_legal) begin
                dst_q <= dec_dst;
                ptr_q <= dec_ptr;
                alt_q <= alt_prefix;
            end
            if (state_q == S_ADDR && half_q) begin
                ea_q  <= ea_sum;
                log_q <= ea_logical;
            end
            if (state_q == S_RD_LO && half_q) lo_q <= mem_data;
            if (state_q == S_RD_HI && half_q) hi_q <= mem_data;
        end
    end

    // outputs
    always_comb begin
        mem_rd  = 1'b0;
        rf_we   = 1'b0;
        done    = 1'b0;
        illegal = 1'b0;
        busy    = 1'b1;
        unique case (state_q)
            S_IDLE:   busy = 1'b0;
            S_PFX:    ;
            S_TRAP:   illegal = 1'b1;
            S_DECODE: ;
            S_ADDR:   ;
            S_RD_LO:  mem_rd = 1'b1;
            S_RD_HI:  mem_rd = 1'b1;
            S_WBACK: begin
                rf_we = half_q;
                done  = half_q;
            end
        endcase
    end

    assign mem_xlate = mem_rd & log_q;
    assign ptr_sel   = ptr_q;
    assign rf_dst    = dst_q;
    assign rf_alt    = alt_q & ~dst_q[1];
    assign rf_wdata  = {hi_q, lo_q};
endmodule

// File: rtl/pol_checker.sv
module pol_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       mem_rd,
    input logic       mem_xlate,
    input logic       done,
    input logic       rf_we,
    input logic [1:0] rf_dst,
    input logic       rf_alt,
    input logic       illegal
);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_rd && !rf_we && !done));

    assert_xlate_needs_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_xlate |-> mem_rd);

    assert_xlate_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && $past(mem_rd)) |-> (mem_xlate == $past(mem_xlate)));

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_length_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy, 9));

    assert_write_after_reads_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> ($past(mem_rd, 2) && !$past(mem_rd, 1)));

    assert_index_no_alt_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we && rf_dst[1]) |-> !rf_alt);

    assert_illegal_no_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !mem_rd ##1 (!busy && !mem_rd));
endmodule

bind ptr_offset_load_unit pol_checker u_pol_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .mem_rd    (mem_rd),
    .mem_xlate (mem_xlate),
    .done      (done),
    .rf_we     (rf_we),
    .rf_dst    (rf_dst),
    .rf_alt    (rf_alt),
    .illegal   (illegal)
);

// File: tb/tb_ptr_offset_load_unit.sv
module tb_ptr_offset_load_unit;
    localparam int PW = 24;

    typedef struct {
        logic [1:0]    dst;
        logic          alt;
        logic [15:0]   data;
        logic [PW-1:0] a_lo;
        logic [PW-1:0] a_hi;
        logic          x;
        int            start;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          op_valid = 1'b0;
    logic [7:0]    op_byte = 8'h00;
    logic          alt_prefix = 1'b0;
    logic [1:0]    ptr_sel;
    logic [31:0]   ptr_val;
    logic [15:0]   hl_val;
    logic          mem_rd;
    logic [PW-1:0] mem_addr;
    logic          mem_xlate;
    logic [7:0]    mem_data;
    logic          rf_we;
    logic [1:0]    rf_dst;
    logic          rf_alt;
    logic [15:0]   rf_wdata;
    logic          busy, done, illegal;

    logic [31:0] ptr_regs [4];
    logic [15:0] hl_reg = 16'h0000;

    int   cyc = 0;
    int   n_vec = 0;
    int   n_bad = 0;
    int   total_rd = 0;
    int   rd_cnt = 0;
    logic [PW-1:0] seen_lo, seen_hi;
    logic seen_xlo, seen_xhi;
    exp_t exp_q [$];

    always #10 clk = ~clk;   // 50 MHz
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [7:0] mem_fn(input logic [PW-1:0] a, input logic x);
        return a[7:0] ^ {a[14:8], a[15]} ^ a[23:16] ^ (x ? 8'hC3 : 8'h00);
    endfunction

    function automatic logic [PW-1:0] map_addr(input logic [31:0] a, input logic lg);
        return lg ? {8'h00, a[15:0]} : a[PW-1:0];
    endfunction

    assign ptr_val  = ptr_regs[ptr_sel];
    assign hl_val   = hl_reg;
    assign mem_data = mem_fn(mem_addr, mem_xlate);

    ptr_offset_load_unit #(.PHYS_W(PW)) dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_byte(op_byte),
        .alt_prefix(alt_prefix), .ptr_sel(ptr_sel), .ptr_val(ptr_val),
        .hl_val(hl_val), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .mem_xlate(mem_xlate), .mem_data(mem_data), .rf_we(rf_we),
        .rf_dst(rf_dst), .rf_alt(rf_alt), .rf_wdata(rf_wdata),
        .busy(busy), .done(done), .illegal(illegal)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] expv);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_rd) begin
                total_rd++;
                if (rd_cnt < 2) begin seen_lo = mem_addr; seen_xlo = mem_xlate; end
                else            begin seen_hi = mem_addr; seen_xhi = mem_xlate; end
                rd_cnt++;
            end
            if (rf_we) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8 unexpected write", 32'(rf_wdata), 32'h0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(rf_dst == e.dst, "R2 destination", 32'(rf_dst), 32'(e.dst));
                    check(rf_alt == e.alt, "R9/R10 alternate select", 32'(rf_alt), 32'(e.alt));
                    check(rf_wdata == e.data, "R6 write data", 32'(rf_wdata), 32'(e.data));
                    check(seen_lo == e.a_lo, "R3 first read address", 32'(seen_lo), 32'(e.a_lo));
                    check(seen_hi == e.a_hi, "R6 second read address", 32'(seen_hi), 32'(e.a_hi));
                    check(seen_xlo == e.x && seen_xhi == e.x, "R4/R5 translate flag",
                          {30'b0, seen_xhi, seen_xlo}, {30'b0, e.x, e.x});
                    check(cyc == e.start + 9 && done, "R7 done in clock 10",
                          32'(cyc - e.start + 1), 32'd10);
                    check(rd_cnt == 4, "R7 read clocks", 32'(rd_cnt), 32'd4);
                end
                rd_cnt = 0;
            end
        end
    end

    task automatic run_load(input logic [1:0] dst, input logic [1:0] ptr,
                            input logic [31:0] pv, input logic [15:0] hl,
                            input logic alt, input bit noise);
        exp_t e;
        logic [31:0] ea, ea1;
        logic lg;
        ptr_regs[ptr] = pv;
        hl_reg = hl;
        ea  = pv + {16'h0000, hl};
        ea1 = ea + 32'd1;
        lg  = (pv[31:16] == 16'hFFFF);
        e.dst  = dst;
        e.alt  = alt & ~dst[1];
        e.a_lo = map_addr(ea, lg);
        e.a_hi = map_addr(ea1, lg);
        e.x    = lg;
        e.data = {mem_fn(e.a_hi, lg), mem_fn(e.a_lo, lg)};
        @(negedge clk); op_valid = 1'b1; op_byte = 8'h6D;
        @(negedge clk); op_byte = {dst, ptr, 4'h2}; alt_prefix = alt;
        @(negedge clk); op_valid = 1'b0; alt_prefix = 1'b0; op_byte = 8'h00;
        e.start = cyc;
        exp_q.push_back(e);
        for (int k = 2; k <= 11; k++) begin
            @(negedge clk);
            if (noise && k == 3) begin op_valid = 1'b1; op_byte = 8'h6D; end
            if (noise && k == 4) begin op_byte = 8'h42; end
            if (noise && k == 5) begin op_valid = 1'b0; op_byte = 8'h00; end
        end
        check(!busy, "R7/R1 idle in clock 11", 32'(busy), 32'd0);
        check(exp_q.size() == 0, "R8 write happened", 32'(exp_q.size()), 32'd0);
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        int rd_before;
        for (int i = 0; i < 4; i++) ptr_regs[i] = 32'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !mem_rd && !rf_we && !done && !illegal, "R1 reset state",
              {27'b0, busy, mem_rd, rf_we, done, illegal}, 32'h0);

        // R1: non-prefix bytes in idle
        op_valid = 1'b1; op_byte = 8'h02;
        @(negedge clk);
        check(!busy, "R1 non-prefix ignored", 32'(busy), 32'd0);
        op_byte = 8'h12;
        @(negedge clk);
        op_valid = 1'b0;
        check(!busy, "R1 stray second byte ignored", 32'(busy), 32'd0);

        // main loads
        run_load(2'b00, 2'b00, 32'h0000_1000, 16'h0234, 1'b0, 0);   // R5 physical
        run_load(2'b01, 2'b01, 32'hFFFF_1200, 16'h0034, 1'b1, 0);   // R4 logical, R9
        run_load(2'b10, 2'b10, 32'h00AB_CDEF, 16'h1111, 1'b1, 0);   // R10
        run_load(2'b11, 2'b11, 32'h1234_5678, 16'hFFFF, 1'b1, 0);   // R3 truncation, R10
        run_load(2'b00, 2'b10, 32'h0001_2FFF, 16'h0000, 1'b1, 0);   // R6 carry, R9
        run_load(2'b01, 2'b11, 32'hFFFF_0000, 16'hFFFF, 1'b0, 0);   // R4 wrap
        run_load(2'b00, 2'b01, 32'hFFFE_FFFF, 16'h0001, 1'b0, 0);   // R5 near-logical
        for (int c = 0; c < 16; c++) begin                          // R2 all codes
            run_load(2'(c >> 2), 2'(c), 32'h0003_0000 + 32'(c) * 32'h1357,
                     16'(c * 16'h0F0F), c[0], 0);
        end
        run_load(2'b01, 2'b00, 32'h0000_4000, 16'h0100, 1'b1, 1);   // R1 busy ignores

        // R11 illegal second byte
        rd_before = total_rd;
        @(negedge clk); op_valid = 1'b1; op_byte = 8'h6D;
        @(negedge clk); op_byte = 8'h43;
        @(negedge clk); op_valid = 1'b0; op_byte = 8'h00;
        check(illegal && !mem_rd, "R11 illegal pulse", {30'b0, illegal, mem_rd}, 32'h2);
        @(negedge clk);
        check(!busy && !illegal, "R11 back to idle", {30'b0, busy, illegal}, 32'h0);
        repeat (10) @(negedge clk);
        check(total_rd == rd_before, "R11 no memory read", 32'(total_rd), 32'(rd_before));

        // a legal load still works after the trap
        run_load(2'b11, 2'b00, 32'hFFFF_8000, 16'h7FFF, 1'b1, 0);   // R10, R4
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule